// File: doc/BRIEF.md
# Command Packet Framer

This block takes a stream of 32-bit words from a graphics command port and cuts it into whole packets. The top byte of the first word of each packet is the opcode. The opcode sets how many words follow, using a fixed length map. Two families of line-strip opcodes have no fixed length. They end on the first word that matches a terminator pattern. A packet that has only partly arrived is held in a small store. Nothing downstream sees any of it until its last word is in.

Every complete packet is replayed one word per cycle on a single output. Each word carries a kind code, the opcode and the word index. Downstream logic uses the kind code to route the packet to the primitive engine, to the image-transfer engines or to the copy engine. Words that set environment state are not replayed: they go straight into an eight-entry register file, which also drives a 13-bit status summary. A one-word interrupt opcode gives a one-cycle pulse. While a packet is being replayed the input is stalled.

Top module: `cmd_packet_framer`

## Requirements
- R1: A packet with a fixed length is 1 + N words. N comes from its opcode:
  - 0x02 → 2
  - 0x20–0x3F, selected by opcode bits 4:2 in the order 0..7 → 3, 6, 4, 8, 5, 8, 7, 11
  - 0x40–0x47 → 2
  - 0x50–0x57 → 3
  - 0x60–0x7F, selected by opcode bits 4:2 in the order 0..7 → 2, 3, 1, 0, 1, 2, 1, 2

  The packet is replayed with indices 0..N, and pkt_last is set only on index N.
- R2: Opcodes 0x48–0x4F (flat strip) close on the first word at index 3 or above for which (word & 0xF000F000) == 0x50005000. That word is part of the packet. Matching words at index 1 or 2 are ordinary data.
- R3: Opcodes 0x58–0x5F (shaded strip) use the same test, but only at even indices of 4 or above. Matching words at odd indices, or below index 4, are ordinary data.
- R4: A strip that reaches BUF_DEPTH words without a terminator is closed at index BUF_DEPTH-1. The next word starts a new packet.
- R5: pkt_kind is one of five codes:
  - 0: primitive
  - 1: CPU-to-memory transfer start, opcodes 0xA0–0xBF, 3 words
  - 2: memory-to-CPU transfer start, opcodes 0xC0–0xDF, 3 words
  - 3: memory-to-memory copy, opcodes 0x80–0x9F, 4 words
  - 4: other

  pkt_op carries the packet's opcode on every word.
- R6: A header word with opcode 0xE0–0xE7 stores the whole word in environment register (opcode & 7) and produces no packet output.
- R7: status[10:0] equals bits 10:0 of environment register 1. status[12:11] equals bits 1:0 of environment register 6.
- R8: A header word with opcode 0x1F gives exactly one cycle of irq_pulse and produces no packet output.
- R9: Any header opcode not covered by R1–R8 is a one-word packet of kind 4.
- R10: No word of a packet appears on the output until its last word has been accepted. Idle cycles between input words neither split a packet nor drop words.
- R11: in_ready is low from the cycle the final word of a packet is accepted until that packet's last word has been output. A word offered during that time is held by the source and is not lost.
- R12: Synchronous reset clears the environment registers, the status and any partly collected packet. After reset, pkt_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Framer can take a word this cycle |
| in_word | input | 32 | Command word |
| pkt_valid | output | 1 | Packet word present on the output |
| pkt_kind | output | 3 | Packet class (R5 codes) |
| pkt_op | output | 8 | Opcode of the packet being output |
| pkt_idx | output | IDX_W (4) | Word index within the packet |
| pkt_last | output | 1 | Final word of the packet |
| pkt_word | output | 32 | Packet word |
| irq_pulse | output | 1 | One-cycle interrupt request flag |
| env_regs | output | 32*ENV_NUM (256) | Environment register file, entry k at bits 32k+31:32k |
| status | output | 13 | Status summary mirrored from registers 1 and 6 |

## Verification
The bench targets several ways the framer could frame packets wrongly:
- Strips are sent with terminator-shaped words placed where they must be ignored: at index 1 or 2 in the flat form, and at odd indices in the shaded form. A framer that tests too early, or tests every word in the shaded form, would close the packet early and start a new packet on a data word.
- The longest fixed opcode and the zero-extra 0x6C opcode exercise both ends of the length map.
- A strip with no terminator checks the forced close at the buffer limit.
- Input gaps, and a reset in the middle of a packet, check that a framer does not output partial packets or keep stale words.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  typedef enum logic [2:0] {
    K_PRIM  = 3'd0,
    K_WRITE = 3'd1,
    K_READ  = 3'd2,
    K_COPY  = 3'd3,
    K_MISC  = 3'd4
  } pkt_kind_e;

  typedef enum logic [1:0] {
    STRIP_NONE   = 2'd0,
    STRIP_FLAT   = 2'd1,
    STRIP_SHADED = 2'd2
  } strip_e;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_EMIT    = 1'b1
  } fsm_e;

  localparam logic [31:0] TERM_MASK  = 32'hF000_F000;
  localparam logic [31:0] TERM_MATCH = 32'h5000_5000;
  localparam int          FLAT_SCAN_FROM   = 3;
  localparam int          SHADED_SCAN_FROM = 4;
  localparam logic [7:0]  OP_IRQ     = 8'h1F;
endpackage

// File: rtl/cmd_len_decode.sv
module cmd_len_decode
  import pkt_framer_pkg::*;
(
  input  logic [7:0] op,
  output logic [3:0] extra,
  output pkt_kind_e  kind,
  output strip_e     strip,
  output logic       is_env,
  output logic       is_irq
);
  always_comb begin
    extra  = 4'd0;
    kind   = K_MISC;
    strip  = STRIP_NONE;
    is_env = 1'b0;
    is_irq = 1'b0;
    if (op == 8'h02) begin
      extra = 4'd2;
      kind  = K_PRIM;
    end else if (op == OP_IRQ) begin
      is_irq = 1'b1;
    end else if (op[7:5] == 3'b001) begin
      kind = K_PRIM;
      case (op[4:2])
        3'd0: extra = 4'd3;
        3'd1: extra = 4'd6;
        3'd2: extra = 4'd4;
        3'd3: extra = 4'd8;
        3'd4: extra = 4'd5;
        3'd5: extra = 4'd8;
        3'd6: extra = 4'd7;
        default: extra = 4'd11;
      endcase
    end else if (op[7:4] == 4'h4) begin
      kind = K_PRIM;
      if (op[3]) begin
        strip = STRIP_FLAT;
        extra = 4'd2;
      end else begin
        extra = 4'd2;
      end
    end else if (op[7:4] == 4'h5) begin
      kind = K_PRIM;
      extra = 4'd3;
      if (op[3]) strip = STRIP_SHADED;
    end else if (op[7:5] == 3'b011) begin
      kind = K_PRIM;
      case (op[4:2])
        3'd0: extra = 4'd2;
        3'd1: extra = 4'd3;
        3'd2: extra = 4'd1;
        3'd3: extra = 4'd0;
        3'd4: extra = 4'd1;
        3'd5: extra = 4'd2;
        3'd6: extra = 4'd1;
        default: extra = 4'd2;
      endcase
    end else if (op[7:5] == 3'b100) begin
      kind  = K_COPY;
      extra = 4'd3;
    end else if (op[7:5] == 3'b101) begin
      kind  = K_WRITE;
      extra = 4'd2;
    end else if (op[7:5] == 3'b110) begin
      kind  = K_READ;
      extra = 4'd2;
    end else if (op[7:3] == 5'b11100) begin
      is_env = 1'b1;
    end
  end
endmodule

// File: rtl/pkt_store.sv
module pkt_store #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/env_regfile.sv
module env_regfile #(
  parameter int NUM   = 8,
  parameter int SEL_W = $clog2(NUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [31:0]       wdata,
  output logic [32*NUM-1:0] regs_flat,
  output logic [12:0]       status
);
  logic [31:0] regs [NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM; i++) regs[i] <= '0;
    end else if (we) begin
      regs[sel] <= wdata;
    end
  end

  // summary kept as its own register, loaded in step with the file
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else if (we) begin
      if (sel == SEL_W'(1)) status[10:0]  <= wdata[10:0];
      if (sel == SEL_W'(6)) status[12:11] <= wdata[1:0];
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_flat
    assign regs_flat[32*g +: 32] = regs[g];
  end
endmodule

// File: rtl/cmd_packet_framer.sv
module cmd_packet_framer
  import pkt_framer_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int ENV_NUM   = 8,
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [31:0]           in_word,
  output logic                  pkt_valid,
  output logic [2:0]            pkt_kind,
  output logic [7:0]            pkt_op,
  output logic [IDX_W-1:0]      pkt_idx,
  output logic                  pkt_last,
  output logic [31:0]           pkt_word,
  output logic                  irq_pulse,
  output logic [32*ENV_NUM-1:0] env_regs,
  output logic [12:0]           status
);
  localparam int ENV_SEL_W = $clog2(ENV_NUM);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(BUF_DEPTH - 1);

  fsm_e             state;
  logic [IDX_W-1:0] cnt, last_idx, emit_ptr;
  logic [7:0]       hdr_op;
  pkt_kind_e        hdr_kind;
  strip_e           hdr_strip;
  logic [3:0]       hdr_extra;

  logic [3:0] dec_extra;
  pkt_kind_e  dec_kind;
  strip_e     dec_strip;
  logic       dec_env, dec_irq;

  cmd_len_decode u_dec (
    .op     (in_word[31:24]),
    .extra  (dec_extra),
    .kind   (dec_kind),
    .strip  (dec_strip),
    .is_env (dec_env),
    .is_irq (dec_irq)
  );

  logic       accept, first, direct, buffered;
  logic [3:0] cur_extra;
  strip_e     cur_strip;
  logic       term_hit, close_fixed, close_flat, close_shaded, close_full, close_now;

  assign in_ready  = (state == ST_COLLECT);
  assign accept    = in_valid && in_ready;
  assign first     = (cnt == '0);
  assign direct    = first && (dec_env || dec_irq);
  assign buffered  = accept && !direct;
  assign cur_extra = first ? dec_extra : hdr_extra;
  assign cur_strip = first ? dec_strip : hdr_strip;
  assign term_hit  = ((in_word & TERM_MASK) == TERM_MATCH);

  assign close_fixed  = (cur_strip == STRIP_NONE) && (cnt == IDX_W'(cur_extra));
  assign close_flat   = (cur_strip == STRIP_FLAT) && (cnt >= IDX_W'(FLAT_SCAN_FROM)) && term_hit;
  assign close_shaded = (cur_strip == STRIP_SHADED) && (cnt >= IDX_W'(SHADED_SCAN_FROM))
                        && !cnt[0] && term_hit;
  assign close_full   = (cnt == LAST_SLOT);
  assign close_now    = close_fixed || close_flat || close_shaded || close_full;

  logic emit_rd;
  assign emit_rd = (state == ST_EMIT);

  pkt_store #(.DEPTH(BUF_DEPTH), .WIDTH(32), .ADDR_W(IDX_W)) u_store (
    .clk     (clk),
    .wr_en   (buffered),
    .wr_addr (cnt),
    .wr_data (in_word),
    .rd_en   (emit_rd),
    .rd_addr (emit_ptr),
    .rd_data (pkt_word)
  );

  env_regfile #(.NUM(ENV_NUM), .SEL_W(ENV_SEL_W)) u_env (
    .clk       (clk),
    .rst       (rst),
    .we        (accept && first && dec_env),
    .sel       (in_word[24 +: ENV_SEL_W]),
    .wdata     (in_word),
    .regs_flat (env_regs),
    .status    (status)
  );

  // collection and sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_COLLECT;
      cnt       <= '0;
      last_idx  <= '0;
      emit_ptr  <= '0;
      hdr_op    <= '0;
      hdr_kind  <= K_MISC;
      hdr_strip <= STRIP_NONE;
      hdr_extra <= '0;
    end else if (state == ST_COLLECT) begin
      if (buffered) begin
        if (first) begin
          hdr_op    <= in_word[31:24];
          hdr_kind  <= dec_kind;
          hdr_strip <= dec_strip;
          hdr_extra <= dec_extra;
        end
        if (close_now) begin
          state    <= ST_EMIT;
          last_idx <= cnt;
          emit_ptr <= '0;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin
      emit_ptr <= emit_ptr + 1'b1;
      if (emit_ptr == last_idx) state <= ST_COLLECT;
    end
  end

  // registered packet side-band, aligned with the store read port
  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_valid <= 1'b0;
      pkt_kind  <= K_MISC;
      pkt_op    <= '0;
      pkt_idx   <= '0;
      pkt_last  <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= accept && first && dec_irq;
      pkt_valid <= emit_rd;
      if (emit_rd) begin
        pkt_kind <= hdr_kind;
        pkt_op   <= hdr_op;
        pkt_idx  <= emit_ptr;
        pkt_last <= (emit_ptr == last_idx);
      end else begin
        pkt_last <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmd_packet_framer_chk.sv
module cmd_packet_framer_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             pkt_valid,
  input logic             pkt_last,
  input logic [2:0]       pkt_kind,
  input logic [7:0]       pkt_op,
  input logic [IDX_W-1:0] pkt_idx,
  input logic [255:0]     env_regs,
  input logic [12:0]      status
);
  // R11: input stalled while a packet is mid-replay
  p_stall_during_replay_r11: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_last) |-> !in_ready);

  // R1: indices step by one inside a packet
  p_index_steps_r1: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_last) |=> (pkt_valid && pkt_idx == $past(pkt_idx) + 1'b1));

  // R10: a packet starts at index 0
  p_starts_at_zero_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_valid) |-> (pkt_idx == '0));

  // R5: kind and opcode hold across one packet
  p_class_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_last) |=> ($stable(pkt_kind) && $stable(pkt_op)));

  // R4: a closed packet is followed by a gap
  p_gap_after_last_r4: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_last) |=> !pkt_valid);

  // R7: status mirrors registers 1 and 6
  p_status_mirror_r7: assert property (@(posedge clk) disable iff (rst)
    status == {env_regs[6*32 +: 2], env_regs[1*32 +: 11]});
endmodule

bind cmd_packet_framer cmd_packet_framer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .pkt_valid (pkt_valid),
  .pkt_last  (pkt_last),
  .pkt_kind  (pkt_kind),
  .pkt_op    (pkt_op),
  .pkt_idx   (pkt_idx),
  .env_regs  (env_regs[255:0]),
  .status    (status)
);

// File: tb/sim_cmd_packet_framer.sv
module sim_cmd_packet_framer;
  localparam int DEPTH = 16;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic in_ready, pkt_valid, pkt_last, irq_pulse;
  logic [2:0] pkt_kind;
  logic [7:0] pkt_op;
  logic [IW-1:0] pkt_idx;
  logic [31:0] pkt_word;
  logic [255:0] env_regs;
  logic [12:0] status;

  always #10 clk = ~clk;

  cmd_packet_framer #(.BUF_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .pkt_valid(pkt_valid), .pkt_kind(pkt_kind), .pkt_op(pkt_op), .pkt_idx(pkt_idx),
    .pkt_last(pkt_last), .pkt_word(pkt_word), .irq_pulse(irq_pulse),
    .env_regs(env_regs), .status(status));

  typedef struct packed {
    logic [2:0]    kind;
    logic [7:0]    op;
    logic [IW-1:0] idx;
    logic          last;
    logic [31:0]   word;
    logic [7:0]    req;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int irq_seen = 0;
  bit finished = 0;
  logic [31:0] pk [32];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_pulse) irq_seen++;
      if (pkt_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected word", {32'h0, pkt_word}, 64'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(pkt_kind == e.kind && pkt_op == e.op && pkt_idx == e.idx &&
                pkt_last == e.last && pkt_word == e.word,
                $sformatf("R%0d packet word", e.req),
                {8'h0, 5'h0, pkt_kind, pkt_op, 3'h0, pkt_last, 4'(pkt_idx), pkt_word},
                {8'h0, 5'h0, e.kind, e.op, 3'h0, e.last, 4'(e.idx), e.word});
          if (!pkt_last) check(!in_ready, "R11 ready low in replay", {63'h0, in_ready}, 64'h0);
        end
      end
    end
  end

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: push expectations, then send words
  task automatic frame(input int n, input logic [2:0] kind, input logic [7:0] req, input int gap);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.kind = kind; e.op = pk[0][31:24]; e.idx = IW'(i);
      e.last = (i == n - 1); e.word = pk[i]; e.req = req;
      exp_q.push_back(e);
    end
    for (int i = 0; i < n; i++) begin
      put(pk[i]);
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic drain;
    int t = 0;
    while (exp_q.size() != 0 && t < 200) begin @(negedge clk); t++; end
    idle(3);
  endtask

  task automatic fill_seq(input logic [31:0] hdr, input int n);
    pk[0] = hdr;
    for (int i = 1; i < n; i++) pk[i] = 32'h0001_0001 * i + 32'h0A00_0300;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(in_ready == 1'b1, "R12 in_ready", {63'h0, in_ready}, 64'h1);
    check(pkt_valid == 1'b0, "R12 pkt_valid", {63'h0, pkt_valid}, 64'h0);
    check(status == 13'h0, "R12 status", {51'h0, status}, 64'h0);
    check(env_regs == '0, "R12 env regs", env_regs[63:0], 64'h0);

    // R1 fixed lengths
    fill_seq(32'h2011_2233, 4);  frame(4, 3'd0, 8'd1, 0); drain();
    fill_seq(32'h3C00_0001, 12); frame(12, 3'd0, 8'd1, 0); drain();
    fill_seq(32'h0200_FFFF, 3);  frame(3, 3'd0, 8'd1, 0); drain();
    fill_seq(32'h6800_0010, 2);  frame(2, 3'd0, 8'd1, 0); drain();
    fill_seq(32'h6C00_0020, 1);  frame(1, 3'd0, 8'd1, 0); drain();
    fill_seq(32'h7400_0030, 3);  frame(3, 3'd0, 8'd1, 0); drain();

    // R5 transfer and copy classes
    fill_seq(32'hA000_0000, 3); frame(3, 3'd1, 8'd5, 0); drain();
    fill_seq(32'hC100_0000, 3); frame(3, 3'd2, 8'd5, 0); drain();
    fill_seq(32'h8000_0000, 4); frame(4, 3'd3, 8'd5, 0); drain();

    // R2 flat strip, early lookalikes ignored
    pk[0] = 32'h4A00_00FF; pk[1] = 32'h5000_5000; pk[2] = 32'h5001_5001;
    pk[3] = 32'h0123_0456; pk[4] = 32'h5555_5555;
    frame(5, 3'd0, 8'd2, 0); drain();

    // R3 shaded strip, odd-index lookalikes ignored
    pk[0] = 32'h5811_2233; pk[1] = 32'h0001_0001; pk[2] = 32'h5000_5000;
    pk[3] = 32'h5500_5500; pk[4] = 32'h0020_0020; pk[5] = 32'h5FFF_5FFF;
    pk[6] = 32'h5000_5000;
    frame(7, 3'd0, 8'd3, 0); drain();

    // R4 strip with no terminator closes at the buffer limit
    pk[0] = 32'h4800_0000;
    for (int i = 1; i < DEPTH; i++) pk[i] = 32'h0000_0100 + i;
    frame(DEPTH, 3'd0, 8'd4, 0);
    fill_seq(32'h0000_0077, 1); frame(1, 3'd4, 8'd4, 0); drain();

    // R10 gaps between words
    fill_seq(32'h2800_0005, 5); frame(5, 3'd0, 8'd10, 3); drain();

    // R11 back-to-back packets with source held off
    fill_seq(32'h4000_0001, 3); frame(3, 3'd0, 8'd11, 0);
    fill_seq(32'h5000_0002, 4); frame(4, 3'd0, 8'd11, 0); drain();

    // R6 / R7 environment writes, no packet output
    put(32'hE100_0ABC);
    put(32'hE600_0003);
    idle(2);
    check(env_regs[32 +: 32] == 32'hE100_0ABC, "R6 reg1", {32'h0, env_regs[32 +: 32]}, 64'hE100_0ABC);
    check(env_regs[192 +: 32] == 32'hE600_0003, "R6 reg6", {32'h0, env_regs[192 +: 32]}, 64'hE600_0003);
    check(status == {2'b11, 11'h2BC}, "R7 status", {51'h0, status}, {51'h0, 2'b11, 11'h2BC});
    put(32'hE300_1234);
    idle(2);
    check(env_regs[96 +: 32] == 32'hE300_1234, "R6 reg3", {32'h0, env_regs[96 +: 32]}, 64'hE300_1234);
    check(status == {2'b11, 11'h2BC}, "R7 status unchanged", {51'h0, status}, {51'h0, 2'b11, 11'h2BC});

    // R8 interrupt words
    put(32'h1F00_0000);
    put(32'h1FAB_CDEF);
    idle(3);
    check(irq_seen == 2, "R8 irq pulses", 64'(irq_seen), 64'd2);

    // R9 unlisted opcodes
    fill_seq(32'h10AB_CDEF, 1); frame(1, 3'd4, 8'd9, 0);
    fill_seq(32'hF000_0001, 1); frame(1, 3'd4, 8'd9, 0); drain();

    // R12 reset mid-packet discards partial words
    put(32'h2000_0000);
    put(32'h0000_0001);
    @(negedge clk); rst = 1'b1;
    idle(2); rst = 1'b0;
    @(negedge clk);
    check(status == 13'h0, "R12 status after reset", {51'h0, status}, 64'h0);
    fill_seq(32'h00AB_CDEF, 1); frame(1, 3'd4, 8'd12, 0); drain();

    check(exp_q.size() == 0, "R10 all words delivered", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule